// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller collects interrupt requests from peripheral sources and latches each one in a sticky flag. It masks the flags with a per-source enable and a global enable. From the requests that are still eligible, it picks the one with the highest priority. A CPU core watches the pending line. When the core takes the interrupt, it pulses the acknowledge strobe. The controller then registers the selected slot's priority index and the address of its vector word, and both values stay steady through the entry sequence.

There are 32 priority slots, and slot 31 ranks highest. Slot n owns the vector word at 0xFFC0 + 2·n, so the table fills the top 64 bytes of memory. Slot 31 is the reset class and slot 30 is the non-maskable class. Neither is gated by any enable. Slots 0 to 29 are maskable.

Every maskable slot has a single request line, except one group slot. Eight pin requests share the group slot, and it is pending whenever any of the eight pin flags is set. Acknowledging a single-source slot clears its flag automatically. The group slot's pin flags stay set until software clears them through a write-one-to-clear input.

Top module: `irq_vec_ctrl`

## Requirements
- R1: When ack_i is high and irq_o is high at a clock edge, vec_o becomes 0xFFC0 + 2·n and prio_o becomes n from that edge on, where n is the selected slot.
- R2: A request on sys_req_i (slot 31, vector 0xFFFE) or on nmi_i (slot 30, vector 0xFFFC) is serviced even when gie_i and every src_en_i bit are 0.
- R3: A maskable slot k (0 to 29) can raise irq_o only when gie_i, src_en_i[k] and slot k's flag are all 1.
- R4: When several slots are eligible, the one with the highest slot number is selected.
- R5: A request that arrives while its slot is masked stays latched, and irq_o rises as soon as the enables allow it.
- R6: Flags are set on the rising edge of a request. A request held high sets its flag only once and does not set it again after it is acknowledged.
- R7: When an acknowledge takes a single-source slot k, flag_clr_o shows a one-hot pulse on bit k in that cycle, and flag k is cleared at the edge.
- R8: The group slot is slot 18 (vector 0xFFE4). It is pending while any of the 8 grp_req_i flags is set. Acknowledging it clears no flag, and flag_clr_o stays 0. Each grp_clr_i bit written as 1 clears the matching pin flag. src_req_i[18] is ignored.
- R9: An ack_i while irq_o is low leaves vec_o and prio_o unchanged and gives no clear pulse.
- R10: vec_o and prio_o change only on an accepted acknowledge.
- R11: After reset, irq_o is 0, vec_o is 0, prio_o is 0 and all flags are clear.
- R12: If a new request edge and a clear for the same flag fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_req_i | input | 30 | Request lines of maskable slots 0 to 29 (bit 18 unused) |
| grp_req_i | input | 8 | Pin requests that share the group slot |
| nmi_i | input | 1 | Non-maskable request, slot 30 |
| sys_req_i | input | 1 | Reset-class request, slot 31 |
| src_en_i | input | 30 | Per-slot enables of slots 0 to 29 |
| gie_i | input | 1 | Global enable for maskable slots |
| ack_i | input | 1 | Acknowledge strobe from the core |
| grp_clr_i | input | 8 | Write-one-to-clear for the group pin flags |
| irq_o | output | 1 | An eligible request is pending |
| vec_o | output | 16 | Registered vector word address |
| prio_o | output | 5 | Registered selected slot index |
| flag_clr_o | output | 32 | Per-slot automatic clear pulse |

## Verification
The hardest case to reach is a new request edge that lands in the same cycle as the acknowledge that clears that flag. To get there, the request must first be raised and acknowledged or dropped, then lowered, and then raised again exactly on the acknowledge edge. A directed sequence does this on one slot, and random stimulus that toggles requests and acknowledges at high rates hits it on many slots. A bench-side model of the flags, enables and group pins predicts irq_o, flag_clr_o, vec_o and prio_o on every cycle, including masked arrivals and group pins that outlive their acknowledge.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int          ADDR_W   = 16;
  localparam logic [15:0] VEC_BASE = 16'hFFC0;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] req_q, flag_q, edge_w;

  assign edge_w = req_i & ~req_q;
  assign flag_o = flag_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      flag_q <= '0;
    end else begin
      req_q  <= req_i;
      flag_q <= (flag_q & ~clr_i) | edge_w;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    assert_edge_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_w[i] |=> flag_q[i]);
    assert_clr_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !edge_w[i]) |=> !flag_q[i]);
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int NUM_SLOTS = 32,
  parameter int NUM_MASK  = 30
) (
  input  logic [NUM_SLOTS-1:0] flag_i,
  input  logic [NUM_MASK-1:0]  en_i,
  input  logic                 gie_i,
  output logic [NUM_SLOTS-1:0] elig_o
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    if (i < NUM_MASK) begin : g_mask
      assign elig_o[i] = flag_i[i] & en_i[i] & gie_i;
    end else begin : g_bypass
      assign elig_o[i] = flag_i[i];
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N     = 32,
  localparam int SEL_W = $clog2(N)
) (
  input  logic [N-1:0]     elig_i,
  output logic             any_o,
  output logic [SEL_W-1:0] sel_o
);
  always_comb begin
    any_o = 1'b0;
    sel_o = '0;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i]) begin
        any_o = 1'b1;
        sel_o = SEL_W'(i);
      end
    end
  end

  always_comb begin
    if (any_o) assert_top_wins_R4: assert ((elig_i >> sel_o) == N'(1));
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int NUM_MASK  = 30,
  parameter int GRP_SLOT  = 18,
  parameter int GRP_W     = 8,
  localparam int SEL_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_MASK-1:0]  src_req_i,
  input  logic [GRP_W-1:0]     grp_req_i,
  input  logic                 nmi_i,
  input  logic                 sys_req_i,
  input  logic [NUM_MASK-1:0]  src_en_i,
  input  logic                 gie_i,
  input  logic                 ack_i,
  input  logic [GRP_W-1:0]     grp_clr_i,
  output logic                 irq_o,
  output logic [ADDR_W-1:0]    vec_o,
  output logic [SEL_W-1:0]     prio_o,
  output logic [NUM_SLOTS-1:0] flag_clr_o
);
  logic [NUM_SLOTS-1:0] slot_req, single_flag, slot_flag, elig, auto_clr;
  logic [GRP_W-1:0]     grp_flag;
  logic                 any;
  logic [SEL_W-1:0]     sel;
  logic                 ack_fire;

  always_comb begin
    slot_req           = {sys_req_i, nmi_i, src_req_i};
    slot_req[GRP_SLOT] = 1'b0;
  end

  irq_flag_bank #(.W(NUM_SLOTS)) u_single (
    .clk_i, .rst_ni, .req_i(slot_req), .clr_i(auto_clr), .flag_o(single_flag)
  );

  irq_flag_bank #(.W(GRP_W)) u_group (
    .clk_i, .rst_ni, .req_i(grp_req_i), .clr_i(grp_clr_i), .flag_o(grp_flag)
  );

  always_comb begin
    slot_flag           = single_flag;
    slot_flag[GRP_SLOT] = |grp_flag;
  end

  irq_gate #(.NUM_SLOTS(NUM_SLOTS), .NUM_MASK(NUM_MASK)) u_gate (
    .flag_i(slot_flag), .en_i(src_en_i), .gie_i, .elig_o(elig)
  );

  irq_prio_enc #(.N(NUM_SLOTS)) u_enc (
    .elig_i(elig), .any_o(any), .sel_o(sel)
  );

  assign ack_fire = ack_i & any;
  assign irq_o    = any;

  // shared vector: software clears pin flags
  always_comb begin
    auto_clr = '0;
    if (ack_fire && sel != SEL_W'(GRP_SLOT)) auto_clr[sel] = 1'b1;
  end
  assign flag_clr_o = auto_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o  <= '0;
      prio_o <= '0;
    end else if (ack_fire) begin
      vec_o  <= VEC_BASE + ADDR_W'({sel, 1'b0});
      prio_o <= sel;
    end
  end

  assert_vec_map_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> (vec_o == VEC_BASE + ADDR_W'({$past(sel), 1'b0}) && prio_o == $past(sel)));
  assert_top_class_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_flag[NUM_SLOTS-1] |-> (irq_o && sel == SEL_W'(NUM_SLOTS-1)));
  assert_mask_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && sel < SEL_W'(NUM_MASK)) |-> (gie_i && src_en_i[sel]));
  assert_grp_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && sel == SEL_W'(GRP_SLOT) && grp_clr_i == '0) |=> (|grp_flag));
  assert_vec_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_i && irq_o) |=> ($stable(vec_o) && $stable(prio_o)));
endmodule

// File: tb/irq_vec_ctrl_bench.sv
module irq_vec_ctrl_bench;
  localparam int NS = 32, NM = 30, GS = 18, GW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NM-1:0] src_req = '0, src_en = '0;
  logic [GW-1:0] grp_req = '0, grp_clr = '0;
  logic nmi = 0, sys_req = 0, gie = 0, ack = 0;
  logic irq_o;
  logic [15:0] vec_o;
  logic [4:0] prio_o;
  logic [NS-1:0] flag_clr_o;

  irq_vec_ctrl u_irq_vec_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_req_i(src_req), .grp_req_i(grp_req),
    .nmi_i(nmi), .sys_req_i(sys_req), .src_en_i(src_en), .gie_i(gie),
    .ack_i(ack), .grp_clr_i(grp_clr), .irq_o(irq_o), .vec_o(vec_o),
    .prio_o(prio_o), .flag_clr_o(flag_clr_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [NS-1:0] m_flag = '0, m_prev = '0;
  logic [GW-1:0] m_grp = '0, m_gprev = '0;
  logic [15:0] m_vec = '0;
  logic [4:0]  m_prio = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NS-1:0] m_elig();
    logic [NS-1:0] f, e;
    f = m_flag;
    f[GS] = |m_grp;
    for (int i = 0; i < NS; i++) e[i] = (i < NM) ? (f[i] & src_en[i] & gie) : f[i];
    return e;
  endfunction

  function automatic int m_sel(logic [NS-1:0] e);
    int s = -1;
    for (int i = 0; i < NS; i++) if (e[i]) s = i;
    return s;
  endfunction

  // one cycle: predict, clock, update model, compare registered outputs
  task automatic step();
    int s;
    logic [NS-1:0] reqv, expclr;
    #2;
    s = m_sel(m_elig());
    chk("R3 irq_o", 32'(irq_o), 32'(s >= 0));
    expclr = (ack && s >= 0 && s != GS) ? (32'd1 << s) : '0;
    chk("R7 flag_clr_o", flag_clr_o, expclr);
    @(posedge clk);
    if (ack && s >= 0) begin
      m_vec  = 16'hFFC0 + 16'(2 * s);
      m_prio = 5'(s);
      if (s != GS) m_flag[s] = 1'b0;
    end
    reqv = {sys_req, nmi, src_req};
    reqv[GS] = 1'b0;
    m_flag = m_flag | (reqv & ~m_prev);
    m_prev = reqv;
    m_grp  = (m_grp & ~grp_clr) | (grp_req & ~m_gprev);
    m_gprev = grp_req;
    #1;
    chk("R1/R10 vec_o", 32'(vec_o), 32'(m_vec));
    chk("R4 prio_o", 32'(prio_o), 32'(m_prio));
  endtask

  logic wd_hit = 0;
  initial begin
    #1_000_000;
    wd_hit = 1;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #23;
    // R11 reset state
    chk("R11 irq", 32'(irq_o), 0);
    chk("R11 vec", 32'(vec_o), 0);
    chk("R11 prio", 32'(prio_o), 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;

    // R5/R3: masked arrival is remembered
    src_req[5] = 1; step();
    chk("R5 masked irq", 32'(irq_o), 0);
    src_en[5] = 1; step();
    chk("R3 gie low irq", 32'(irq_o), 0);
    gie = 1; #2;
    chk("R5 released irq", 32'(irq_o), 1);
    ack = 1; step(); ack = 0;
    chk("R1 slot5 vec", 32'(vec_o), 32'hFFCA);
    step();
    chk("R6 held request no re-set", 32'(irq_o), 0);
    src_req = '0; step();

    // R2: bypass classes
    gie = 0; src_en = '0; nmi = 1; step();
    chk("R2 nmi irq", 32'(irq_o), 1);
    ack = 1; step(); ack = 0;
    chk("R2 nmi vec", 32'(vec_o), 32'hFFFC);
    sys_req = 1; step();
    ack = 1; step(); ack = 0;
    chk("R2 reset-class vec", 32'(vec_o), 32'hFFFE);
    nmi = 0; sys_req = 0; step();

    // R4: simultaneous
    gie = 1; src_en = '1;
    src_req[3] = 1; src_req[12] = 1; src_req[29] = 1; step();
    ack = 1; step();
    chk("R4 first", 32'(prio_o), 29);
    step();
    chk("R4 second", 32'(prio_o), 12);
    step(); ack = 0;
    chk("R4 third", 32'(prio_o), 3);
    // R9: ack with nothing pending
    ack = 1; step(); ack = 0;
    chk("R9 vec unchanged", 32'(vec_o), 32'hFFC6);
    src_req = '0; step();

    // R8: shared slot
    grp_req = 8'h81; src_req[GS] = 1; step();
    ack = 1; step();
    chk("R8 grp vec", 32'(vec_o), 32'hFFE4);
    step(); ack = 0;
    chk("R8 still pending", 32'(irq_o), 1);
    grp_clr = 8'h01; step();
    chk("R8 one pin left", 32'(irq_o), 1);
    grp_clr = 8'h80; step(); grp_clr = '0;
    chk("R8 all cleared", 32'(irq_o), 0);
    grp_req = '0; src_req = '0; step();

    // R12: new edge during its own clear
    src_req[7] = 1; step();
    src_req[7] = 0; step();
    src_req[7] = 1; ack = 1; step(); ack = 0;
    chk("R12 prio", 32'(prio_o), 7);
    chk("R12 flag kept", 32'(irq_o), 1);
    ack = 1; step(); ack = 0; src_req = '0; step();

    // random mix
    for (int n = 0; n < 3000; n++) begin
      src_req = src_req ^ (NM'($urandom) & NM'($urandom) & NM'($urandom));
      grp_req = grp_req ^ (GW'($urandom) & GW'($urandom));
      nmi     = ($urandom % 16) == 0;
      sys_req = ($urandom % 32) == 0;
      src_en  = NM'($urandom) | NM'($urandom);
      gie     = ($urandom % 4) != 0;
      ack     = ($urandom % 2) == 0;
      grp_clr = (($urandom % 4) == 0) ? GW'($urandom) : '0;
      step();
    end

    if (!wd_hit) begin
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule